// File: doc/BRIEF.md
# Nonvolatile Write Sequencer with Busy Polling

This block controls the slow nonvolatile write that follows any bus command that changes a stored setting register. The command decoder passes a pending write request to the sequencer. The request carries the target pot or the global flag, the register select and the data for every pot. Nothing happens while the command is still on the bus. The write cycle is armed only by the stop condition that closes the command. A start condition that arrives before that stop drops the request.

While the write cycle runs, the block is busy. The decoder is held off and every address byte on the bus is refused. A master can therefore poll by sending address bytes until one is acknowledged. When the cycle timer expires, the block emits a one-cycle commit strobe with the captured target and data, and it frees the bus on that same edge.

A second, independent path delays a wiper load from a stored register. The visible wiper update appears a fixed, short number of cycles after the load is accepted.

Top module: `nvw_busy_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), busy=0, cmd_en=1, commit_valid=0 and wiper_upd_valid=0.
- R2: A stop_evt sampled while a request is pending sets busy on that same clock edge. busy then stays high for exactly WR_TICKS cycles.
- R3: ack_en is 0 whenever busy is 1, including in the last busy cycle. While busy is 0, ack_en equals addr_strobe.
- R4: cmd_en is the inverse of busy. While busy is 1, the inputs req_valid, wload_valid, start_evt and stop_evt have no effect: no request is captured, no wiper update follows, and no later stop starts a cycle.
- R5: commit_valid pulses for one cycle, on the edge where busy clears. commit_reg and commit_data hold the pending request. commit_mask has only bit P set for a single-pot write to pot P, and is all ones for a global write.
- R6: A start_evt sampled while a request is pending, with no stop_evt in the same cycle, discards the request. A stop_evt with no pending request starts no cycle.
- R7: A wiper load accepted while not busy makes wiper_upd_valid pulse for one cycle, LOAD_TICKS edges after the accepting edge, carrying that load's pot and data. A newer load that arrives before the update is issued replaces the older one.
- R8: A second request that arrives before the stop replaces the first, and only the second request is committed.
- R9: A stop_evt and a wiper load in the same cycle both take effect. The wiper update is issued during the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Decoder presents a nonvolatile write request |
| req_global | input | 1 | Request targets the selected register of every pot |
| req_pot | input | POT_W | Target pot for a single-pot request |
| req_reg | input | REG_W | Register select within the pot(s) |
| req_data | input | NUM_POTS*DATA_W | Data per pot, pot k in slice k |
| start_evt | input | 1 | Bus start condition seen |
| stop_evt | input | 1 | Bus stop condition seen |
| addr_strobe | input | 1 | Address byte matched; the ack decision is due |
| wload_valid | input | 1 | Load of a wiper from a stored register |
| wload_pot | input | POT_W | Pot of the wiper load |
| wload_data | input | DATA_W | Wiper value to load |
| ack_en | output | 1 | Acknowledge the current address byte |
| cmd_en | output | 1 | Command decoder enable |
| busy | output | 1 | Write cycle in progress |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_mask | output | NUM_POTS | Pots written by the commit |
| commit_reg | output | REG_W | Register written by the commit |
| commit_data | output | NUM_POTS*DATA_W | Data to store, per pot |
| wiper_upd_valid | output | 1 | Delayed wiper update strobe |
| wiper_upd_pot | output | POT_W | Pot of the wiper update |
| wiper_upd_data | output | DATA_W | New wiper value |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes each on purpose. The first pair is a polling address byte and the end of the write cycle. The bench strobes an address in the final busy cycle and expects a refusal. It strobes again on the edge that raises the commit and expects an acknowledge. The second pair is the arming stop and a wiper load. The bench drives both in one cycle and expects the wiper update to come out at its fixed delay inside the busy window, with the commit still on time. Random write traffic wraps these cases, with random garbage on every input during busy.

// File: rtl/nvw_pkg.sv
// Package: shared types for the nonvolatile write sequencer.
package nvw_pkg;
    // Phases of a nonvolatile write request.
    typedef enum logic [1:0] {
        NVW_IDLE    = 2'd0,
        NVW_ARMED   = 2'd1,
        NVW_WRITING = 2'd2
    } nvw_state_e;
endpackage

// File: rtl/nvw_cycle_timer.sv
// Module: nvw_cycle_timer
// Counts the write cycle down from TICKS once it is loaded. 'last' is high in
// the final counted cycle. Assumes 'load' is given only while not running.
module nvw_cycle_timer #(
    parameter int TICKS = 250000,
    localparam int CNT_W = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic running,
    output logic last
);
    logic [CNT_W-1:0] cnt;

    assign running = (cnt != '0);
    assign last    = (cnt == CNT_W'(1));

    // Load on request, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load)    cnt <= CNT_W'(TICKS);
        else if (running) cnt <= cnt - CNT_W'(1);
    end
endmodule

// File: rtl/nvw_wiper_delay.sv
// Module: nvw_wiper_delay
// Holds an accepted wiper load and releases it as a one-cycle update, DELAY
// edges after the accepting edge. A new accept restarts the delay.
// Assumes DELAY >= 1.
module nvw_wiper_delay #(
    parameter int DELAY  = 8,
    parameter int POT_W  = 2,
    parameter int DATA_W = 6,
    localparam int CNT_W = $clog2(DELAY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [POT_W-1:0]  in_pot,
    input  logic [DATA_W-1:0] in_data,
    output logic              upd_valid,
    output logic [POT_W-1:0]  upd_pot,
    output logic [DATA_W-1:0] upd_data
);
    logic [CNT_W-1:0] cnt;

    // Capture the load value; it stays stable until the next accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_pot  <= '0;
            upd_data <= '0;
        end else if (accept) begin
            upd_pot  <= in_pot;
            upd_data <= in_data;
        end
    end

    // Count the delay and pulse the update when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            upd_valid <= 1'b0;
        end else begin
            upd_valid <= 1'b0;
            if (accept) begin
                cnt <= CNT_W'(DELAY);
            end else if (cnt == CNT_W'(1)) begin
                cnt       <= '0;
                upd_valid <= 1'b1;
            end else if (cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/nvw_arm_ctrl.sv
// Module: nvw_arm_ctrl
// Holds the pending write request. A stop arms the write cycle and a start
// aborts the request. On the last timer cycle it issues the commit.
// Assumes the timer's 'last' is valid only in the WRITING state.
module nvw_arm_ctrl
    import nvw_pkg::*;
#(
    parameter int NUM_POTS = 4,
    parameter int REG_W    = 2,
    parameter int DATA_W   = 6,
    localparam int POT_W   = $clog2(NUM_POTS),
    localparam int VEC_W   = NUM_POTS * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_global,
    input  logic [POT_W-1:0]    req_pot,
    input  logic [REG_W-1:0]    req_reg,
    input  logic [VEC_W-1:0]    req_data,
    input  logic                start_evt,
    input  logic                stop_evt,
    input  logic                tmr_last,
    output logic                launch,
    output logic                busy,
    output logic                commit_valid,
    output logic [NUM_POTS-1:0] commit_mask,
    output logic [REG_W-1:0]    commit_reg,
    output logic [VEC_W-1:0]    commit_data
);
    nvw_state_e       state;
    logic             pend_glob;
    logic [POT_W-1:0] pend_pot;
    logic             capture;

    assign launch  = (state == NVW_ARMED) && stop_evt;
    assign capture = req_valid && ((state == NVW_IDLE) ||
                     ((state == NVW_ARMED) && !stop_evt));
    assign busy    = (state == NVW_WRITING);

    // Phase sequencing: arm on request, write on stop, drop on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= NVW_IDLE;
        end else begin
            unique case (state)
                NVW_IDLE:    if (req_valid) state <= NVW_ARMED;
                NVW_ARMED:   if (stop_evt) state <= NVW_WRITING;
                             else if (start_evt && !req_valid) state <= NVW_IDLE;
                NVW_WRITING: if (tmr_last) state <= NVW_IDLE;
                default:     state <= NVW_IDLE;
            endcase
        end
    end

    // Latch the newest request; hold it through the write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_glob   <= 1'b0;
            pend_pot    <= '0;
            commit_reg  <= '0;
            commit_data <= '0;
        end else if (capture) begin
            pend_glob   <= req_global;
            pend_pot    <= req_pot;
            commit_reg  <= req_reg;
            commit_data <= req_data;
        end
    end

    // One-cycle commit on the edge that ends the write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) commit_valid <= 1'b0;
        else        commit_valid <= busy && tmr_last;
    end

    // Per-pot write enable: every pot for global, otherwise the selected one.
    for (genvar k = 0; k < NUM_POTS; k++) begin : g_mask
        assign commit_mask[k] = pend_glob || (pend_pot == POT_W'(k));
    end
endmodule

// File: rtl/nvw_busy_seq.sv
// Module: nvw_busy_seq (top)
// Sequences nonvolatile writes after the closing stop. It refuses address
// bytes and gates the decoder while busy, and it delays wiper loads.
// Assumes start/stop/strobe inputs are single-cycle, synchronous events.
module nvw_busy_seq #(
    parameter int NUM_POTS   = 4,
    parameter int REG_W      = 2,
    parameter int DATA_W     = 6,
    parameter int WR_TICKS   = 250000,
    parameter int LOAD_TICKS = 8,
    localparam int POT_W     = $clog2(NUM_POTS),
    localparam int VEC_W     = NUM_POTS * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_global,
    input  logic [POT_W-1:0]    req_pot,
    input  logic [REG_W-1:0]    req_reg,
    input  logic [VEC_W-1:0]    req_data,
    input  logic                start_evt,
    input  logic                stop_evt,
    input  logic                addr_strobe,
    input  logic                wload_valid,
    input  logic [POT_W-1:0]    wload_pot,
    input  logic [DATA_W-1:0]   wload_data,
    output logic                ack_en,
    output logic                cmd_en,
    output logic                busy,
    output logic                commit_valid,
    output logic [NUM_POTS-1:0] commit_mask,
    output logic [REG_W-1:0]    commit_reg,
    output logic [VEC_W-1:0]    commit_data,
    output logic                wiper_upd_valid,
    output logic [POT_W-1:0]    wiper_upd_pot,
    output logic [DATA_W-1:0]   wiper_upd_data
);
    logic launch;
    logic tmr_running;
    logic tmr_last;
    logic busy_i;

    // Bus-facing gating: refuse addresses and hold off the decoder while busy.
    assign busy   = busy_i;
    assign cmd_en = !busy_i;
    assign ack_en = addr_strobe && !busy_i;

    nvw_arm_ctrl #(
        .NUM_POTS(NUM_POTS), .REG_W(REG_W), .DATA_W(DATA_W)
    ) u_arm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid && !busy_i), .req_global(req_global),
        .req_pot(req_pot), .req_reg(req_reg), .req_data(req_data),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .tmr_last(tmr_last && tmr_running),
        .launch(launch), .busy(busy_i),
        .commit_valid(commit_valid), .commit_mask(commit_mask),
        .commit_reg(commit_reg), .commit_data(commit_data)
    );

    nvw_cycle_timer #(.TICKS(WR_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(launch),
        .running(tmr_running), .last(tmr_last)
    );

    nvw_wiper_delay #(
        .DELAY(LOAD_TICKS), .POT_W(POT_W), .DATA_W(DATA_W)
    ) u_wdly (
        .clk(clk), .rst_n(rst_n),
        .accept(wload_valid && !busy_i),
        .in_pot(wload_pot), .in_data(wload_data),
        .upd_valid(wiper_upd_valid), .upd_pot(wiper_upd_pot),
        .upd_data(wiper_upd_data)
    );
endmodule

// File: rtl/nvw_busy_seq_chk.sv
// Module: nvw_busy_seq_chk
// Temporal checks on the sequencer's ports. It is bound into every instance.
module nvw_busy_seq_chk #(
    parameter int NUM_POTS   = 4,
    parameter int WR_TICKS   = 250000,
    parameter int LOAD_TICKS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stop_evt,
    input logic                wload_valid,
    input logic                ack_en,
    input logic                busy,
    input logic                commit_valid,
    input logic [NUM_POTS-1:0] commit_mask,
    input logic                wiper_upd_valid
);
    logic [31:0] busy_cnt;
    logic [31:0] wl_cnt;

    // Length of the current busy window, in edges.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 32'd1;
        else           busy_cnt <= '0;
    end

    // Edges since the last accepted wiper load (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)                       wl_cnt <= 32'hFFFF_FFFF;
        else if (wload_valid && !busy)    wl_cnt <= '0;
        else if (wl_cnt != 32'hFFFF_FFFF) wl_cnt <= wl_cnt + 32'd1;
    end

    p_busy_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));
    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_cnt == WR_TICKS);
    p_nack_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack_en);
    p_commit_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (!busy && $past(busy)));
    p_commit_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> !commit_valid);
    p_commit_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> ($countones(commit_mask) == 1 || commit_mask == '1));
    p_wiper_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wiper_upd_valid |-> wl_cnt == LOAD_TICKS);
endmodule

bind nvw_busy_seq nvw_busy_seq_chk #(
    .NUM_POTS(NUM_POTS), .WR_TICKS(WR_TICKS), .LOAD_TICKS(LOAD_TICKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .wload_valid(wload_valid),
    .ack_en(ack_en), .busy(busy), .commit_valid(commit_valid),
    .commit_mask(commit_mask), .wiper_upd_valid(wiper_upd_valid)
);

// File: tb/sim_nvw_busy_seq.sv
module sim_nvw_busy_seq;
    localparam int NP = 4;
    localparam int RW = 2;
    localparam int DW = 6;
    localparam int WT = 29;
    localparam int LT = 5;
    localparam int PW = 2;
    localparam int VW = NP * DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_global = 0, start_evt = 0, stop_evt = 0;
    logic addr_strobe = 0, wload_valid = 0;
    logic [PW-1:0] req_pot = 0, wload_pot = 0;
    logic [RW-1:0] req_reg = 0;
    logic [VW-1:0] req_data = 0;
    logic [DW-1:0] wload_data = 0;
    logic ack_en, cmd_en, busy, commit_valid, wiper_upd_valid;
    logic [NP-1:0] commit_mask;
    logic [RW-1:0] commit_reg;
    logic [VW-1:0] commit_data;
    logic [PW-1:0] wiper_upd_pot;
    logic [DW-1:0] wiper_upd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    nvw_busy_seq #(.NUM_POTS(NP), .REG_W(RW), .DATA_W(DW),
                   .WR_TICKS(WT), .LOAD_TICKS(LT)) u0 (.*);

    function automatic logic [NP-1:0] exp_mask(input logic g, input logic [PW-1:0] p);
        return g ? '1 : (NP'(1) << p);
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        req_valid = 0; start_evt = 0; stop_evt = 0;
        addr_strobe = 0; wload_valid = 0;
    endtask

    task automatic send_req(input logic g, input logic [PW-1:0] p,
                            input logic [RW-1:0] r, input logic [VW-1:0] d);
        req_valid = 1; req_global = g; req_pot = p; req_reg = r; req_data = d;
        step();
        req_valid = 0;
    endtask

    // Called at the sample after the arming edge. wexp: sample index of the wiper update, or -1.
    task automatic run_busy(input logic [NP-1:0] em, input logic [RW-1:0] er,
                            input logic [VW-1:0] ed, input int wexp,
                            input logic [PW-1:0] wp, input logic [DW-1:0] wd);
        chk(busy === 1'b1, "R2", "busy after stop", 32'(busy), 1);
        for (int i = 2; i <= WT; i++) begin
            addr_strobe = 1'($urandom_range(0, 1));
            req_valid   = 1'($urandom_range(0, 1));
            req_data    = VW'($urandom);
            wload_valid = 1'($urandom_range(0, 1));
            start_evt   = 1'($urandom_range(0, 1));
            stop_evt    = 1'($urandom_range(0, 1));
            if (i == WT) addr_strobe = 1;
            #1;
            chk(ack_en === 1'b0, "R3", "ack while busy", 32'(ack_en), 0);
            chk(cmd_en === 1'b0, "R4", "cmd_en while busy", 32'(cmd_en), 0);
            step();
            chk(busy === 1'b1, "R2", "busy held", 32'(busy), 1);
            chk(commit_valid === 1'b0, "R5", "early commit", 32'(commit_valid), 0);
            if (i == wexp)
                chk(wiper_upd_valid === 1'b1 && wiper_upd_pot == wp && wiper_upd_data == wd,
                    "R9", "wiper update in busy", {wiper_upd_pot, wiper_upd_data}, {wp, wd});
            else
                chk(wiper_upd_valid === 1'b0, "R4", "wiper quiet", 32'(wiper_upd_valid), 0);
        end
        idle_inputs();
        addr_strobe = 1; stop_evt = 1;
        step();
        chk(busy === 1'b0, "R2", "busy end", 32'(busy), 0);
        chk(commit_valid === 1'b1, "R5", "commit pulse", 32'(commit_valid), 1);
        chk(commit_mask == em, "R5", "commit mask", 32'(commit_mask), 32'(em));
        chk(commit_reg == er, "R5", "commit reg", 32'(commit_reg), 32'(er));
        chk(commit_data == ed, "R5", "commit data", 32'(commit_data), 32'(ed));
        chk(ack_en === 1'b1, "R3", "ack after cycle", 32'(ack_en), 1);
        chk(cmd_en === 1'b1, "R4", "cmd_en after", 32'(cmd_en), 1);
        idle_inputs();
        for (int i = 0; i <= LT; i++) begin
            step();
            chk(busy === 1'b0, "R4", "no rearm from busy inputs", 32'(busy), 0);
            chk(commit_valid === 1'b0, "R5", "single pulse", 32'(commit_valid), 0);
            chk(wiper_upd_valid === 1'b0, "R4", "busy load ignored", 32'(wiper_upd_valid), 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [VW-1:0] d;
        logic [VW-1:0] d2;
        void'($urandom(32'h1F2E3D4C));
        step(); step();
        rst_n = 1;
        #1;
        chk(busy === 1'b0, "R1", "reset busy", 32'(busy), 0);
        chk(cmd_en === 1'b1, "R1", "reset cmd_en", 32'(cmd_en), 1);
        chk(commit_valid === 1'b0, "R1", "reset commit", 32'(commit_valid), 0);
        chk(wiper_upd_valid === 1'b0, "R1", "reset wiper", 32'(wiper_upd_valid), 0);
        step();

        // R6: stop with nothing pending.
        stop_evt = 1; step(); stop_evt = 0;
        repeat (3) begin
            step();
            chk(busy === 1'b0, "R6", "stop without request", 32'(busy), 0);
        end

        // R7: wiper delay, then a replaced load.
        wload_valid = 1; wload_pot = 2; wload_data = 6'h2A; step(); wload_valid = 0;
        for (int i = 1; i <= LT; i++) begin
            chk(wiper_upd_valid === 1'b0, "R7", "wiper before delay", 32'(wiper_upd_valid), 0);
            step();
        end
        chk(wiper_upd_valid === 1'b1 && wiper_upd_pot == 2 && wiper_upd_data == 6'h2A,
            "R7", "wiper update", {wiper_upd_pot, wiper_upd_data}, {2'd2, 6'h2A});
        wload_valid = 1; wload_pot = 1; wload_data = 6'h11; step();
        wload_pot = 3; wload_data = 6'h3C; step(); wload_valid = 0;
        for (int i = 1; i <= LT; i++) begin
            chk(wiper_upd_valid === 1'b0, "R7", "replaced load quiet", 32'(wiper_upd_valid), 0);
            step();
        end
        chk(wiper_upd_valid === 1'b1 && wiper_upd_pot == 3 && wiper_upd_data == 6'h3C,
            "R7", "newest load wins", {wiper_upd_pot, wiper_upd_data}, {2'd3, 6'h3C});
        step();

        // R8: second request replaces first.
        d = VW'(24'hABCDEF); d2 = VW'(24'h123456);
        send_req(1'b0, 2'd1, 2'd3, d);
        send_req(1'b1, 2'd0, 2'd2, d2);
        stop_evt = 1; step(); stop_evt = 0;
        run_busy(exp_mask(1'b1, 2'd0), 2'd2, d2, -1, 0, 0);

        // R9: stop and wiper load in the same cycle.
        d = VW'(24'h0F0F0F);
        send_req(1'b0, 2'd3, 2'd1, d);
        stop_evt = 1; wload_valid = 1; wload_pot = 0; wload_data = 6'h15;
        step(); stop_evt = 0; wload_valid = 0;
        run_busy(exp_mask(1'b0, 2'd3), 2'd1, d, LT + 1, 2'd0, 6'h15);

        // Random traffic with occasional aborts (R6) and address polls (R3).
        for (int t = 0; t < 40; t++) begin
            logic g; logic [PW-1:0] p; logic [RW-1:0] r; logic ab; int gap;
            g = 1'($urandom_range(0, 1)); p = PW'($urandom); r = RW'($urandom);
            d = VW'($urandom); ab = ($urandom_range(0, 3) == 0);
            gap = $urandom_range(0, 3);
            send_req(g, p, r, d);
            for (int k = 0; k < gap; k++) begin
                addr_strobe = 1'($urandom_range(0, 1));
                #1;
                chk(ack_en === addr_strobe, "R3", "ack idle", 32'(ack_en), 32'(addr_strobe));
                step();
                addr_strobe = 0;
                chk(busy === 1'b0, "R2", "no busy before stop", 32'(busy), 0);
            end
            if (ab) begin
                start_evt = 1; step(); start_evt = 0;
                stop_evt = 1; step(); stop_evt = 0;
                repeat (3) begin
                    step();
                    chk(busy === 1'b0, "R6", "aborted request", 32'(busy), 0);
                end
            end else begin
                stop_evt = 1; step(); stop_evt = 0;
                run_busy(exp_mask(g, p), r, d, -1, 0, 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule